// File: doc/BRIEF.md
# Counting Barrier Synchronizer

This block holds a group of processors at a common meeting point. Each processor raises its arrival request and then waits. No processor is let go until every one of the `NPROC` participants has been counted in. When the last participant is counted, the block lets the processors go one at a time. Each one that leaves gets a single-cycle release pulse. Once the last participant has left, the barrier is ready for the next episode.

Inside, one shared occupancy count sits between two gates. The entry gate is open in state `S_GATHER`. Each admission raises the count by one. The exit gate is open in state `S_DRAIN`. Each departure lowers the count by one. Only one gate is open at any time, so a new episode cannot start until the count has drained back to zero. This is what keeps consecutive barriers apart.

At most one admission or one departure is taken per clock cycle. When several requests are pending, the lowest index wins. A request that arrives while the entry gate is shut stays pending and is admitted once the gate reopens.

The controller has two states and two transitions:
- `S_GATHER`: the entry gate is open.
- `S_DRAIN`: the exit gate is open.
- `LAST_ARRIVAL` (`S_GATHER` to `S_DRAIN`): taken on the admission that brings the count to `NPROC`.
- `LAST_DEPARTURE` (`S_DRAIN` to `S_GATHER`): taken on the departure that brings the count to zero.

Top module: `barrier_sync_unit`

## Requirements
- R1: After reset the count is zero and the block is in `S_GATHER`, with the exit gate shut and all `release_o` bits low.
- R2: In `S_GATHER`, exactly one pending request is admitted per clock edge, the lowest index first. A pending request is one where `arrive_req[i]` is high and processor i has not yet been admitted in this episode.
- R3: No `release_o` bit goes high while fewer than `NPROC` processors have been admitted in the current episode.
- R4: The admission that brings the count to `NPROC` takes `LAST_ARRIVAL`. On the next edge the lowest-index admitted processor departs, and its `release_o` bit is high for the cycle after that edge.
- R5: In `S_DRAIN`, exactly one admitted processor departs per edge, in ascending index order. Each departure makes its `release_o` bit high for exactly one cycle, and at most one bit is high at a time.
- R6: The departure that brings the count to zero takes `LAST_DEPARTURE`. A request held high during `S_DRAIN` is held pending and is not admitted before that transition. It is admitted on the first edge after the transition.
- R7: A processor that is already admitted and keeps `arrive_req` high is not counted again within the same episode.
- R8: Back-to-back episodes with requests held high repeat with a period of 2×`NPROC` cycles. Each episode releases every processor once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_req | input | NPROC | Per-processor arrival request, level |
| release_o | output | NPROC | Per-processor release pulse, one cycle |

## Verification
Each admission takes effect on the clock edge that follows the request. A release bit is registered, so it appears on the edge that performs the departure and is sampled at the next falling edge. When all `NPROC` requests arrive together before edge E, releases are due after edges E+`NPROC` through E+2×`NPROC`−1. The scoreboard computes these edge numbers from the requirements for every stimulus pattern and queues them. The monitor compares `release_o` against the queue at every falling edge, expecting all zeros wherever no release is queued. This also catches any early release.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
    typedef enum logic {
        S_GATHER = 1'b0,
        S_DRAIN  = 1'b1
    } bar_state_e;
endpackage

// File: rtl/barrier_pick.sv
// Fixed-priority picker: the lowest set index wins.
module barrier_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant,
    output logic         any
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;
    for (genvar i = 0; i < W; i++) begin : g_pick
        assign grant[i]   = req[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | req[i];
    end
    assign any = seen[W];
endmodule

// File: rtl/barrier_count.sv
// Shared occupancy count with increment/decrement and boundary flags.
module barrier_count #(
    parameter int NPROC = 4,
    parameter int CNT_W = $clog2(NPROC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count,
    output logic             at_last,
    output logic             at_one
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(NPROC - 1);
    localparam logic [CNT_W-1:0] FULL_V = CNT_W'(NPROC);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + ONE_V;
        else if (dec) count <= count - ONE_V;
    end

    assign at_last = (count == LAST_V);
    assign at_one  = (count == ONE_V);

    // R2: the count never passes the participant number
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_V);
    // R5: a decrement is never requested on an empty count
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (count != '0));
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit
    import barrier_pkg::*;
#(
    parameter int NPROC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPROC-1:0] arrive_req,
    output logic [NPROC-1:0] release_o
);
    localparam int CNT_W = $clog2(NPROC + 1);

    bar_state_e       state_q, state_d;
    logic [NPROC-1:0] joined_q;
    logic [NPROC-1:0] pend_arr, arr_gnt, dep_gnt;
    logic             arr_any, dep_any;
    logic             entry_open, exit_open;
    logic             take_arr, take_dep;
    logic [CNT_W-1:0] count;
    logic             at_last, at_one;

    // gates derived from the phase
    assign entry_open = (state_q == S_GATHER);
    assign exit_open  = (state_q == S_DRAIN);

    assign pend_arr = arrive_req & ~joined_q;

    barrier_pick #(.W(NPROC)) u_arr_pick (
        .req(pend_arr), .grant(arr_gnt), .any(arr_any));
    barrier_pick #(.W(NPROC)) u_dep_pick (
        .req(joined_q), .grant(dep_gnt), .any(dep_any));

    assign take_arr = entry_open & arr_any;
    assign take_dep = exit_open & dep_any;

    barrier_count #(.NPROC(NPROC), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .inc(take_arr), .dec(take_dep),
        .count(count), .at_last(at_last), .at_one(at_one));

    // next-state: LAST_ARRIVAL and LAST_DEPARTURE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_GATHER: if (take_arr && at_last) state_d = S_DRAIN;
            S_DRAIN:  if (take_dep && at_one)  state_d = S_GATHER;
            default:  state_d = S_GATHER;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_GATHER;
        else        state_q <= state_d;
    end

    // outputs and per-processor membership
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            joined_q  <= '0;
            release_o <= '0;
        end else begin
            joined_q  <= (joined_q | (take_arr ? arr_gnt : '0))
                         & ~(take_dep ? dep_gnt : '0);
            release_o <= take_dep ? dep_gnt : '0;
        end
    end

    // R5: at most one release bit at a time
    p_onehot_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(release_o));
    // R3: a release only follows a cycle spent draining
    p_no_early_rel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (release_o != '0) |-> $past(state_q == S_DRAIN));
    // R5: every draining cycle departs someone
    p_drain_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN) |=> (release_o != '0));
    // R6: the last departure reopens the entry gate with an empty count
    p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DRAIN && at_one) |=> (state_q == S_GATHER && count == '0));
    // R7: membership and count agree, so nobody is counted twice
    p_members_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(joined_q) == int'(count));
    // R4: reaching full occupancy switches to draining
    p_full_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) == NPROC) |-> (state_q == S_DRAIN));
endmodule

// File: tb/tb_barrier_sync_unit.sv
module tb_barrier_sync_unit;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] arrive_req = '0;
    logic [NP-1:0] release_o;

    always #10 clk = ~clk; // 50 MHz

    barrier_sync_unit #(.NPROC(NP)) dut (
        .clk(clk), .rst_n(rst_n), .arrive_req(arrive_req), .release_o(release_o));

    typedef struct {
        int    cyc;
        int    idx;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   compared = 0;
    int   mismatched = 0;
    bit   running = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic expect_rel(int c, int i, string t);
        exp_t e;
        e.cyc = c; e.idx = i; e.tag = t;
        q.push_back(e);
    endtask

    task automatic at_neg(int c);
        @(negedge clk);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // monitor: compare each cycle against the scoreboard
    always @(negedge clk) begin
        if (rst_n && running) begin
            logic [NP-1:0] exp_v;
            string         tag;
            exp_v = '0;
            tag   = "R3";
            if (q.size() > 0 && q[0].cyc == cyc) begin
                exp_v = NP'(1) << q[0].idx;
                tag   = q[0].tag;
                void'(q.pop_front());
            end
            compared++;
            if (release_o !== exp_v) begin
                mismatched++;
                $display("FAIL %s cycle %0d release_o actual=%b expected=%b",
                         tag, cyc, release_o, exp_v);
            end
        end
    end

    initial begin
        int e;
        repeat (3) @(negedge clk);
        compared++; // R1: reset state
        if (release_o !== '0) begin
            mismatched++;
            $display("FAIL R1 release_o actual=%b expected=%b", release_o, {NP{1'b0}});
        end
        rst_n   = 1'b1;
        running = 1'b1;

        // all arrive together, held high for two back-to-back episodes
        @(negedge clk);
        e = cyc + 1;
        arrive_req = '1;
        expect_rel(e + 4, 0, "R2");
        for (int i = 1; i < NP; i++) expect_rel(e + 4 + i, i, "R5");
        expect_rel(e + 12, 0, "R6");
        expect_rel(e + 13, 1, "R7");
        expect_rel(e + 14, 2, "R8");
        expect_rel(e + 15, 3, "R8");
        at_neg(e + 12);
        arrive_req = '0;
        at_neg(e + 20);

        // staggered arrivals with a long wait for the last one
        e = cyc + 1;
        arrive_req[3] = 1'b1;
        at_neg(e + 2);  arrive_req[1] = 1'b1;
        at_neg(e + 4);  arrive_req[2] = 1'b1;
        at_neg(e + 29); arrive_req[0] = 1'b1;
        expect_rel(e + 31, 0, "R4");
        for (int i = 1; i < NP; i++) expect_rel(e + 31 + i, i, "R5");
        at_neg(e + 31);
        arrive_req = '0;
        at_neg(e + 40);

        // two pairs; the later pair is split by priority
        e = cyc + 1;
        arrive_req[1] = 1'b1;
        arrive_req[2] = 1'b1;
        at_neg(e + 5);
        arrive_req[0] = 1'b1;
        arrive_req[3] = 1'b1;
        for (int i = 0; i < NP; i++) expect_rel(e + 8 + i, i, "R2");
        at_neg(e + 8);
        arrive_req = '0;
        at_neg(e + 16);

        running = 1'b0;
        if (q.size() != 0) begin
            compared++;
            mismatched++;
            $display("FAIL R5 releases outstanding actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL R5 watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule